// File: doc/BRIEF.md
# Edge/Level Selectable Interrupt Collector

This block gathers a set of peripheral interrupt request lines into a pending register and combines that register with an enable mask to produce a single interrupt output for a processor. A mode input decides how a request is recognised and how its pending bit goes away. In edge mode a rising line marks its bit pending, and the bit remains pending until software clears it. In level mode the pending register simply follows the request lines, and software has no write access to it.

Software reaches the two registers through a minimal port: a one-bit register select, a write strobe, write data and combinational read data. The lowest lines are treated as non-maskable and always reach the processor when pending. The processor interrupt is driven from a flop, so it follows the pending and mask state by one clock.

Top module: `irqc_top`

## Requirements
- R1: While reset is active and for the reset-release cycles, the pending register and the mask register read as zero and `cpu_irq` is low; `level_mode` low (0) selects edge mode, which is therefore the mode of a block whose input is tied low.
- R2: In edge mode a pending bit stays set until a status write (`reg_addr` = 0) carries a 0 in that bit position; a 1 in the written data leaves that bit unchanged and never sets it.
- R3: In edge mode a 0-to-1 change of a request line sets its pending bit at the first clock edge that samples the new value; a line that stays high does not set its bit again after the bit has been cleared.
- R4: In level mode (`level_mode` = 1, taking effect one clock after it changes) each pending bit equals its request line as sampled at the previous clock edge, so a bit clears when its line goes low.
- R5: In level mode a status write has no effect: the pending register keeps the value given by the request lines regardless of the written data.
- R6: A request sets its pending bit whether or not the line is enabled; a pending line numbered 2 or higher whose mask bit is 0 does not raise `cpu_irq`.
- R7: Lines 0 and 1 raise `cpu_irq` whenever their pending bit is set, whatever the mask register holds.
- R8: Writing with `reg_addr` = 1 loads the mask register with `reg_wdata`; `reg_rdata` shows the pending register when `reg_addr` = 0 and the mask register when `reg_addr` = 1, without a clock of delay.
- R9: In edge mode, when a rising edge on a line and a status write clearing that same bit meet in one clock, the bit is left set.
- R10: `cpu_irq` is a flop output: it goes high one clock after a pending bit and an enabling mask bit (or non-maskable position) are both present, and low one clock after the last such pair goes away.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| level_mode | input | 1 | 0 selects edge mode, 1 selects level mode |
| irq_line | input | NLINES | Peripheral request lines, synchronous to clk |
| reg_addr | input | 1 | Register select: 0 pending status, 1 mask |
| reg_we | input | 1 | Write strobe for the selected register |
| reg_wdata | input | NLINES | Write data |
| reg_rdata | output | NLINES | Read data of the selected register |
| cpu_irq | output | 1 | Interrupt to the processor |

## Verification
The assertions take for granted that the request lines, the mode input and the register port are already synchronous to the clock and carry defined values from reset onward, since the block itself does no synchronisation of them. The stimulus changes every input only on the falling clock edge, holds all of them at zero through reset, and changes the mode only while the request lines are quiet, so each property sees clean single-clock transitions. Collisions between an edge and a clear are produced deliberately, but only in edge mode, where the rule for them is defined.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [0:0] {
    SEL_STATUS = 1'b0,
    SEL_MASK   = 1'b1
  } reg_sel_e;

  typedef enum logic [0:0] {
    MODE_EDGE  = 1'b0,
    MODE_LEVEL = 1'b1
  } trig_mode_e;
endpackage

// File: rtl/irqc_rst_sync.sv
module irqc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/irqc_req_detect.sv
module irqc_req_detect
  import irqc_pkg::*;
#(
  parameter int NLINES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              level_mode,
  input  logic [NLINES-1:0] irq_line,
  output trig_mode_e        mode_q,
  output logic [NLINES-1:0] line_q,
  output logic [NLINES-1:0] set_req
);
  trig_mode_e        mode_d;
  logic [NLINES-1:0] line_d;
  logic [NLINES-1:0] rise;

  always_comb begin
    mode_d = level_mode ? MODE_LEVEL : MODE_EDGE;
    line_d = irq_line;
    rise   = irq_line & ~line_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_EDGE;
      line_q <= '0;
    end else begin
      mode_q <= mode_d;
      line_q <= line_d;
    end
  end

  always_comb begin
    if (mode_q == MODE_LEVEL) set_req = irq_line;
    else                      set_req = rise;
  end
endmodule

// File: rtl/irqc_status.sv
module irqc_status
  import irqc_pkg::*;
#(
  parameter int NLINES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  trig_mode_e        mode_q,
  input  logic [NLINES-1:0] irq_line,
  input  logic [NLINES-1:0] set_req,
  input  logic              wr_en,
  input  logic [NLINES-1:0] wr_data,
  output logic [NLINES-1:0] st_q
);
  logic              sw_clear_en;
  logic              hw_drop_en;
  logic [NLINES-1:0] st_d;

  always_comb begin
    sw_clear_en = wr_en && (mode_q == MODE_EDGE);
    hw_drop_en  = (mode_q == MODE_LEVEL);
  end

  for (genvar i = 0; i < NLINES; i++) begin : g_bit
    logic clr_bit;
    logic drop_bit;
    always_comb begin
      clr_bit  = sw_clear_en & ~wr_data[i];
      drop_bit = hw_drop_en & ~irq_line[i];
      st_d[i]  = (st_q[i] & ~clr_bit & ~drop_bit) | set_req[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/irqc_gate.sv
module irqc_gate #(
  parameter int NLINES    = 32,
  parameter int NMI_LINES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mask_we,
  input  logic [NLINES-1:0] mask_wdata,
  input  logic [NLINES-1:0] st_q,
  output logic [NLINES-1:0] msk_q,
  output logic              cpu_irq
);
  logic [NLINES-1:0] bypass;
  logic [NLINES-1:0] msk_d;
  logic [NLINES-1:0] live;
  logic              irq_d;

  for (genvar i = 0; i < NLINES; i++) begin : g_byp
    assign bypass[i] = (i < NMI_LINES);
  end

  always_comb begin
    msk_d = mask_we ? mask_wdata : msk_q;
    live  = st_q & (msk_q | bypass);
    irq_d = |live;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msk_q   <= '0;
      cpu_irq <= 1'b0;
    end else begin
      msk_q   <= msk_d;
      cpu_irq <= irq_d;
    end
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int NLINES     = 32,
  parameter int NMI_LINES  = 2,
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              level_mode,
  input  logic [NLINES-1:0] irq_line,
  input  logic              reg_addr,
  input  logic              reg_we,
  input  logic [NLINES-1:0] reg_wdata,
  output logic [NLINES-1:0] reg_rdata,
  output logic              cpu_irq
);
  logic              rst_sync_n;
  trig_mode_e        mode_q;
  logic [NLINES-1:0] line_q;
  logic [NLINES-1:0] set_req;
  logic [NLINES-1:0] st_q;
  logic [NLINES-1:0] msk_q;
  reg_sel_e          sel;
  logic              st_we;
  logic              mask_we;

  always_comb begin
    sel     = reg_sel_e'(reg_addr);
    st_we   = reg_we && (sel == SEL_STATUS);
    mask_we = reg_we && (sel == SEL_MASK);
    reg_rdata = (sel == SEL_MASK) ? msk_q : st_q;
  end

  irqc_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  irqc_req_detect #(.NLINES(NLINES)) u_det (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .level_mode (level_mode),
    .irq_line   (irq_line),
    .mode_q     (mode_q),
    .line_q     (line_q),
    .set_req    (set_req)
  );

  irqc_status #(.NLINES(NLINES)) u_st (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .mode_q   (mode_q),
    .irq_line (irq_line),
    .set_req  (set_req),
    .wr_en    (st_we),
    .wr_data  (reg_wdata),
    .st_q     (st_q)
  );

  irqc_gate #(.NLINES(NLINES), .NMI_LINES(NMI_LINES)) u_gate (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .mask_we    (mask_we),
    .mask_wdata (reg_wdata),
    .st_q       (st_q),
    .msk_q      (msk_q),
    .cpu_irq    (cpu_irq)
  );
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
  import irqc_pkg::*;
#(
  parameter int NLINES    = 32,
  parameter int NMI_LINES = 2
) (
  input logic              clk,
  input logic              rst_ok_n,
  input trig_mode_e        mode_q,
  input logic [NLINES-1:0] irq_line,
  input logic [NLINES-1:0] line_q,
  input logic              reg_addr,
  input logic              reg_we,
  input logic [NLINES-1:0] reg_wdata,
  input logic [NLINES-1:0] st_q,
  input logic [NLINES-1:0] msk_q,
  input logic              cpu_irq
);
  logic [NLINES-1:0] nmi_pos;
  for (genvar i = 0; i < NLINES; i++) begin : g_nmi
    assign nmi_pos[i] = (i < NMI_LINES);
  end

  always @(negedge clk) begin
    if (rst_ok_n == 1'b0) begin
      AST_RESET_CLEAR: assert (st_q == '0 && msk_q == '0 && !cpu_irq); // R1
    end
  end

  AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (mode_q == MODE_EDGE && !(reg_we && reg_addr == 1'b0))
      |=> ((st_q & $past(st_q)) == $past(st_q))); // R2

  AST_EDGE_SET: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (mode_q == MODE_EDGE)
      |=> ((st_q & $past(irq_line & ~line_q)) == $past(irq_line & ~line_q))); // R3

  AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (mode_q == MODE_LEVEL) |=> (st_q == $past(irq_line))); // R4

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_ok_n)
    ((st_q & (msk_q | nmi_pos)) == '0) |=> !cpu_irq); // R6

  AST_NMI_PASS: assert property (@(posedge clk) disable iff (!rst_ok_n)
    ((st_q & nmi_pos) != '0) |=> cpu_irq); // R7

  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (reg_we && reg_addr == 1'b1) |=> (msk_q == $past(reg_wdata))); // R8

  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_ok_n)
    ((st_q & msk_q) != '0) |=> cpu_irq); // R10
endmodule

bind irqc_top irqc_checker #(.NLINES(NLINES), .NMI_LINES(NMI_LINES)) u_chk (
  .clk       (clk),
  .rst_ok_n  (rst_sync_n),
  .mode_q    (mode_q),
  .irq_line  (irq_line),
  .line_q    (line_q),
  .reg_addr  (reg_addr),
  .reg_we    (reg_we),
  .reg_wdata (reg_wdata),
  .st_q      (st_q),
  .msk_q     (msk_q),
  .cpu_irq   (cpu_irq)
);

// File: tb/tb_irqc_top.sv
module tb_irqc_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;

  logic          clk;
  logic          rst_n;
  logic          level_mode;
  logic [N-1:0]  irq_line;
  logic          reg_addr;
  logic          reg_we;
  logic [N-1:0]  reg_wdata;
  logic [N-1:0]  reg_rdata;
  logic          cpu_irq;

  int n_chk;
  int n_bad;
  bit done;

  irqc_top #(.NLINES(N), .NMI_LINES(2), .RST_STAGES(2)) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .level_mode (level_mode),
    .irq_line   (irq_line),
    .reg_addr   (reg_addr),
    .reg_we     (reg_we),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .cpu_irq    (cpu_irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [N-1:0] d);
    reg_addr  = a;
    reg_we    = 1'b1;
    reg_wdata = d;
    @(negedge clk);
    reg_we    = 1'b0;
    reg_wdata = '0;
  endtask

  task automatic rd(input logic a, output logic [N-1:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic t_reset();
    logic [N-1:0] v;
    rst_n = 1'b0;
    cyc(3);
    rd(1'b0, v); chk("R1 status in reset", v, '0);
    rd(1'b1, v); chk("R1 mask in reset", v, '0);
    chk("R1 cpu_irq in reset", {31'b0, cpu_irq}, '0);
    rst_n = 1'b1;
    cyc(4);
    rd(1'b0, v); chk("R1 status after release", v, '0);
    chk("R1 cpu_irq after release", {31'b0, cpu_irq}, '0);
  endtask

  task automatic t_edge();
    logic [N-1:0] v;
    irq_line[5] = 1'b1;
    cyc(1);
    rd(1'b0, v); chk("R3 rise sets bit 5", v, 32'h20);
    cyc(3);
    rd(1'b0, v); chk("R2 bit 5 holds", v, 32'h20);
    chk("R6 unmasked-off line 5 keeps cpu_irq low", {31'b0, cpu_irq}, '0);
    wr(1'b0, ~32'h20);
    rd(1'b0, v); chk("R2 write 0 clears bit 5", v, '0);
    cyc(2);
    rd(1'b0, v); chk("R3 held-high line does not re-set", v, '0);
    irq_line[5] = 1'b0;
    irq_line[9] = 1'b1;
    cyc(1);
    irq_line[9] = 1'b0;
    cyc(1);
    wr(1'b0, '1);
    rd(1'b0, v); chk("R2 writing ones keeps bit 9 only", v, 32'h200);
    wr(1'b0, '0);
    rd(1'b0, v); chk("R2 write zero clears all", v, '0);
  endtask

  task automatic t_collision();
    logic [N-1:0] v;
    irq_line[7] = 1'b1;
    cyc(1);
    irq_line[7] = 1'b0;
    cyc(1);
    irq_line[7] = 1'b1;
    wr(1'b0, '0);
    rd(1'b0, v); chk("R9 edge beats clear", v, 32'h80);
    cyc(1);
    rd(1'b0, v); chk("R9 bit stays after collision", v, 32'h80);
    wr(1'b0, '0);
    rd(1'b0, v); chk("R2 later clear works", v, '0);
    irq_line[7] = 1'b0;
    cyc(1);
  endtask

  task automatic t_mask();
    logic [N-1:0] v;
    irq_line[10] = 1'b1;
    cyc(1);
    irq_line[10] = 1'b0;
    rd(1'b0, v); chk("R6 masked line still pending", v, 32'h400);
    cyc(2);
    chk("R6 masked line no cpu_irq", {31'b0, cpu_irq}, '0);
    wr(1'b1, 32'h400);
    rd(1'b1, v); chk("R8 mask readback", v, 32'h400);
    chk("R10 cpu_irq not yet high", {31'b0, cpu_irq}, '0);
    cyc(1);
    chk("R10 cpu_irq high one clock later", {31'b0, cpu_irq}, 32'h1);
    wr(1'b0, '0);
    chk("R10 cpu_irq still high right after clear", {31'b0, cpu_irq}, 32'h1);
    cyc(1);
    chk("R10 cpu_irq drops", {31'b0, cpu_irq}, '0);
    wr(1'b1, '0);
    rd(1'b1, v); chk("R8 mask cleared", v, '0);
  endtask

  task automatic t_nmi();
    logic [N-1:0] v;
    irq_line[0] = 1'b1;
    cyc(1);
    irq_line[0] = 1'b0;
    chk("R10 nmi0 one clock lag", {31'b0, cpu_irq}, '0);
    cyc(1);
    chk("R7 line 0 bypasses mask", {31'b0, cpu_irq}, 32'h1);
    wr(1'b0, '0);
    cyc(1);
    chk("R7 cpu_irq low after nmi0 clear", {31'b0, cpu_irq}, '0);
    irq_line[1] = 1'b1;
    cyc(1);
    irq_line[1] = 1'b0;
    cyc(1);
    chk("R7 line 1 bypasses mask", {31'b0, cpu_irq}, 32'h1);
    rd(1'b0, v); chk("R7 status bit 1", v, 32'h2);
    wr(1'b0, '0);
    cyc(1);
  endtask

  task automatic t_level();
    logic [N-1:0] v;
    level_mode = 1'b1;
    cyc(2);
    irq_line[4] = 1'b1;
    cyc(1);
    rd(1'b0, v); chk("R4 level follows high line", v, 32'h10);
    wr(1'b0, '0);
    rd(1'b0, v); chk("R5 write zero ignored", v, 32'h10);
    wr(1'b0, '1);
    rd(1'b0, v); chk("R5 write ones ignored", v, 32'h10);
    irq_line[4] = 1'b0;
    cyc(1);
    rd(1'b0, v); chk("R4 line low clears bit", v, '0);
    irq_line[3] = 1'b1;
    irq_line[20] = 1'b1;
    cyc(1);
    rd(1'b0, v); chk("R4 two lines", v, 32'h100008);
    irq_line[3] = 1'b0;
    irq_line[20] = 1'b0;
    cyc(1);
    rd(1'b0, v); chk("R4 both cleared", v, '0);
    level_mode = 1'b0;
    cyc(2);
  endtask

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    level_mode = 1'b0;
    irq_line   = '0;
    reg_addr   = 1'b0;
    reg_we     = 1'b0;
    reg_wdata  = '0;
    rst_n      = 1'b0;
    t_reset();
    t_edge();
    t_collision();
    t_mask();
    t_nmi();
    t_level();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule